// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is a single DMA channel that copies data from memory into a fixed peripheral data register, one burst at a time, paced by a request line from that peripheral. Software fills in a descriptor through a small register write port. The descriptor holds:

- the source and destination addresses and a signed step for each;
- the access width on each side and the byte count moved per request;
- a current iteration count and the value it reloads from;
- signed end-of-block corrections for both addresses;
- two policy bits: raise an interrupt at the end of the block, and switch the channel off at the end of the block.

Software starts a block by setting the channel enable. Each request from the peripheral then moves one inner burst (a minor loop) of read-then-write beats over a simple single-outstanding memory master port. When the last inner burst of the block (the major loop) finishes, the engine applies the end corrections, reloads the iteration count, raises a sticky done flag and, if asked to, an interrupt. A failed destination write stops the channel and raises a sticky error flag.

Top module: `dma_chan_engine`

## Requirements
- R1: Register write port, word index on `cfg_idx`:
  - 0: source address.
  - 1: destination address.
  - 2: steps, source step in bits 15:0 and destination step in bits 31:16, both signed.
  - 3: sizes, source code in bits 1:0 and destination code in bits 9:8.
  - 4: bytes per request.
  - 5: current iteration count.
  - 6: reload iteration count.
  - 7: signed source end correction.
  - 8: signed destination end correction.
  - 9: policy, interrupt-at-end in bit 0 and disable-at-end in bit 1.
  - 10: command. Each bit acts when written as 1: bit 0 sets the enable, bit 1 clears the enable, bit 2 clears done, bit 3 clears the interrupt, bit 4 clears the error.
- R2: While the enable (`chan_en`) is 0, a pulse on `dreq` starts no memory access and is not remembered.
- R3: Each serviced request performs one inner burst.
  - The burst has (bytes per request >> source size code) beats, with a minimum of 1.
  - Each beat reads the source, then writes the value read to the destination.
  - `mem_size` carries the size code of the current access: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit (code 3 acts as 2).
- R4: After every completed source read, the source address moves by the signed source step. After every completed destination write, the destination address moves by the signed destination step. A step of 0 keeps that address fixed.
- R5: The current iteration count drops by one at the end of each inner burst. The burst that ends with a count of 1 (or 0) completes the block.
- R6: On block completion, the source end correction is added to the source address and the destination end correction to the destination address. The current count reloads from the reload count.
- R7: `done_o` goes to 1 on block completion and stays 1 until command bit 2 is written.
- R8: If interrupt-at-end is set, `irq_o` goes to 1 on block completion and stays 1 until command bit 3 is written. Clearing done leaves it untouched. With the bit clear, `irq_o` stays 0.
- R9: If disable-at-end is set, the enable is cleared on block completion, so later requests are ignored. With the bit clear, the enable stays set.
- R10: A request that arrives during an inner burst is held and serviced right after that burst ends. Several requests during one burst merge into one.
- R11: A destination write answered with `mem_err` ends the burst at once. It sets `err_o`, clears the enable, and leaves the iteration count and destination address unchanged. Command bit 4 clears `err_o`.
- R12: After reset, `done_o`, `irq_o`, `err_o`, `chan_en` and `mem_req` are all 0.
- R13: Once raised, `mem_req` stays high, with the same address and direction, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor word index |
| cfg_wdata | input | 32 | Descriptor write data |
| dreq | input | 1 | Peripheral request pulse, one cycle per request |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| chan_en | output | 1 | Channel enable state |
| done_o | output | 1 | Sticky block-complete flag |
| irq_o | output | 1 | Sticky completion interrupt |
| err_o | output | 1 | Sticky transfer error flag |

## Verification
The engine is driven with several descriptor shapes:

- **Word copy into a fixed register.** One 32-bit beat per request, source step 4, destination step 0, a negative source correction, and disable-at-end. Running this block twice shows that the correction really returns the source to the buffer start, and that the count reloads.
- **Halfword burst.** Four 16-bit beats per request, both addresses stepping. Its requests are pulsed in the middle of a running burst, which separates correct holding of pending work from dropping or duplicating it. Because disable-at-end is clear, this shape also shows that the channel stays enabled.
- **Single-iteration byte burst.** This case separates a block that ends at a count of 1 from one that ends at a count of 0.
- **Failed destination write.** The next block shows the effect: done arrives one request later than it would if the count had been consumed, and the destination restarts at its old address.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_st_e;

  localparam logic [3:0] IDX_SRC   = 4'd0;
  localparam logic [3:0] IDX_DST   = 4'd1;
  localparam logic [3:0] IDX_STEP  = 4'd2;
  localparam logic [3:0] IDX_SIZE  = 4'd3;
  localparam logic [3:0] IDX_CHUNK = 4'd4;
  localparam logic [3:0] IDX_ITER  = 4'd5;
  localparam logic [3:0] IDX_LOAD  = 4'd6;
  localparam logic [3:0] IDX_SADJ  = 4'd7;
  localparam logic [3:0] IDX_DADJ  = 4'd8;
  localparam logic [3:0] IDX_FLAGS = 4'd9;
  localparam logic [3:0] IDX_CMD   = 4'd10;

  localparam int CMD_EN_SET   = 0;
  localparam int CMD_EN_CLR   = 1;
  localparam int CMD_DONE_CLR = 2;
  localparam int CMD_IRQ_CLR  = 3;
  localparam int CMD_ERR_CLR  = 4;

  localparam int POL_IRQ  = 0;
  localparam int POL_STOP = 1;

  // size code 3 is treated as a 32-bit access
  function automatic logic [1:0] size_clamp(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              src_adv,
  input  logic              dst_adv,
  input  logic              loop_end,
  input  logic              xfer_abort,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [1:0]        src_sz,
  output logic [1:0]        dst_sz,
  output logic [CNT_W-1:0]  chunk,
  output logic              chan_en,
  output logic              flag_done,
  output logic              flag_irq,
  output logic              flag_err
);

  localparam int EXT_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n;
  logic [ADDR_W-1:0] sadj_q, sadj_n, dadj_q, dadj_n;
  logic [STEP_W-1:0] sstep_q, sstep_n, dstep_q, dstep_n;
  logic [1:0]        ssz_q, ssz_n, dsz_q, dsz_n;
  logic [CNT_W-1:0]  chunk_q, chunk_n, iter_q, iter_n, load_q, load_n;
  logic              irqen_q, irqen_n, stop_q, stop_n;
  logic              en_q, en_n, done_q, done_n, irq_q, irq_n, err_q, err_n;

  logic [ADDR_W-1:0] sstep_ext, dstep_ext;
  logic              last_iter, major;
  logic              wr_cmd;

  assign sstep_ext = {{EXT_W{sstep_q[STEP_W-1]}}, sstep_q};
  assign dstep_ext = {{EXT_W{dstep_q[STEP_W-1]}}, dstep_q};
  assign last_iter = (iter_q <= CNT_W'(1));
  assign major     = loop_end && last_iter;
  assign wr_cmd    = cfg_we && (cfg_idx == IDX_CMD);

  // next-state: hardware events first, software writes take priority
  always_comb begin
    src_n   = src_q;
    dst_n   = dst_q;
    sadj_n  = sadj_q;
    dadj_n  = dadj_q;
    sstep_n = sstep_q;
    dstep_n = dstep_q;
    ssz_n   = ssz_q;
    dsz_n   = dsz_q;
    chunk_n = chunk_q;
    iter_n  = iter_q;
    load_n  = load_q;
    irqen_n = irqen_q;
    stop_n  = stop_q;
    en_n    = en_q;
    done_n  = done_q;
    irq_n   = irq_q;
    err_n   = err_q;

    if (src_adv) src_n = src_n + sstep_ext;
    if (major)   src_n = src_n + sadj_q;
    if (dst_adv) dst_n = dst_n + dstep_ext;
    if (major)   dst_n = dst_n + dadj_q;

    if (loop_end) iter_n = last_iter ? load_q : (iter_q - CNT_W'(1));

    if (major) begin
      done_n = 1'b1;
      if (irqen_q) irq_n = 1'b1;
      if (stop_q)  en_n  = 1'b0;
    end
    if (xfer_abort) begin
      err_n = 1'b1;
      en_n  = 1'b0;
    end

    if (cfg_we) begin
      unique case (cfg_idx)
        IDX_SRC:   src_n = cfg_wdata[ADDR_W-1:0];
        IDX_DST:   dst_n = cfg_wdata[ADDR_W-1:0];
        IDX_STEP: begin
          sstep_n = cfg_wdata[STEP_W-1:0];
          dstep_n = cfg_wdata[2*STEP_W-1:STEP_W];
        end
        IDX_SIZE: begin
          ssz_n = cfg_wdata[1:0];
          dsz_n = cfg_wdata[9:8];
        end
        IDX_CHUNK: chunk_n = cfg_wdata[CNT_W-1:0];
        IDX_ITER:  iter_n  = cfg_wdata[CNT_W-1:0];
        IDX_LOAD:  load_n  = cfg_wdata[CNT_W-1:0];
        IDX_SADJ:  sadj_n  = cfg_wdata[ADDR_W-1:0];
        IDX_DADJ:  dadj_n  = cfg_wdata[ADDR_W-1:0];
        IDX_FLAGS: begin
          irqen_n = cfg_wdata[POL_IRQ];
          stop_n  = cfg_wdata[POL_STOP];
        end
        default: ;
      endcase
    end

    if (wr_cmd) begin
      if (cfg_wdata[CMD_EN_SET])   en_n   = 1'b1;
      if (cfg_wdata[CMD_EN_CLR])   en_n   = 1'b0;
      if (cfg_wdata[CMD_DONE_CLR]) done_n = 1'b0;
      if (cfg_wdata[CMD_IRQ_CLR])  irq_n  = 1'b0;
      if (cfg_wdata[CMD_ERR_CLR])  err_n  = 1'b0;
    end
  end

  // descriptor fields: loaded by software, no reset needed for function,
  // but reset keeps outputs defined
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      sadj_q  <= '0;
      dadj_q  <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      ssz_q   <= '0;
      dsz_q   <= '0;
      chunk_q <= '0;
      iter_q  <= '0;
      load_q  <= '0;
      irqen_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      src_q   <= src_n;
      dst_q   <= dst_n;
      sadj_q  <= sadj_n;
      dadj_q  <= dadj_n;
      sstep_q <= sstep_n;
      dstep_q <= dstep_n;
      ssz_q   <= ssz_n;
      dsz_q   <= dsz_n;
      chunk_q <= chunk_n;
      iter_q  <= iter_n;
      load_q  <= load_n;
      irqen_q <= irqen_n;
      stop_q  <= stop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      en_q   <= en_n;
      done_q <= done_n;
      irq_q  <= irq_n;
      err_q  <= err_n;
    end
  end

  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign src_sz    = size_clamp(ssz_q);
  assign dst_sz    = size_clamp(dsz_q);
  assign chunk     = chunk_q;
  assign chan_en   = en_q;
  assign flag_done = done_q;
  assign flag_irq  = irq_q;
  assign flag_err  = err_q;

  // R5: a non-final burst takes exactly one off the count
  p_iter_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end && (iter_q > CNT_W'(1)) && !cfg_we) |=> (iter_q == $past(iter_q) - CNT_W'(1)));

  // R6: the final burst reloads the count
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end && (iter_q <= CNT_W'(1)) && !cfg_we) |=> (iter_q == $past(load_q)));

  // R7: block completion leaves done set
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end && (iter_q <= CNT_W'(1)) && !cfg_we) |=> done_q);

  // R9: disable-at-end drops the enable
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_end && (iter_q <= CNT_W'(1)) && stop_q && !cfg_we) |=> !en_q);

  // R11: an abort flags error, stops the channel, keeps count and destination
  p_abort_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_abort && !cfg_we) |=> (err_q && !en_q && $stable(iter_q) && $stable(dst_q)));

endmodule

// File: rtl/dma_req_track.sv
module dma_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic chan_en,
  input  logic take,
  output logic pend
);

  logic pend_q, pend_n;

  always_comb begin
    if (!chan_en) pend_n = 1'b0;
    else          pend_n = (pend_q && !take) || dreq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign pend = pend_q;

  // R10: pending work not yet taken survives while the channel is on
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take && chan_en) |=> pend_q);

  // R2: a disabled channel remembers nothing
  p_pend_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !pend_q);

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              chan_en,
  input  logic [CNT_W-1:0]  chunk,
  input  logic [1:0]        src_sz,
  input  logic [1:0]        dst_sz,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              take,
  output logic              src_adv,
  output logic              dst_adv,
  output logic              loop_end,
  output logic              xfer_abort,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata
);

  xfer_st_e          st_q, st_n;
  logic [CNT_W-1:0]  beat_q, beat_n, beats_raw, beats;
  logic [DATA_W-1:0] hold_q;
  logic              hold_ce;

  assign beats_raw = chunk >> src_sz;
  assign beats     = (beats_raw == '0) ? CNT_W'(1) : beats_raw;

  always_comb begin
    st_n       = st_q;
    beat_n     = beat_q;
    take       = 1'b0;
    src_adv    = 1'b0;
    dst_adv    = 1'b0;
    loop_end   = 1'b0;
    xfer_abort = 1'b0;
    hold_ce    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend && chan_en) begin
          take   = 1'b1;
          beat_n = beats;
          st_n   = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          hold_ce = 1'b1;
          src_adv = 1'b1;
          st_n    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (mem_err) begin
            xfer_abort = 1'b1;
            st_n       = ST_IDLE;
          end else begin
            dst_adv = 1'b1;
            if (beat_q <= CNT_W'(1)) begin
              loop_end = 1'b1;
              st_n     = ST_IDLE;
            end else begin
              beat_n = beat_q - CNT_W'(1);
              st_n   = ST_READ;
            end
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_n;
      beat_q <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= mem_rdata;
  end

  always_comb begin
    mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
    mem_we    = (st_q == ST_WRITE);
    mem_addr  = mem_we ? dst_addr : src_addr;
    mem_size  = mem_we ? dst_sz : src_sz;
    mem_wdata = hold_q;
  end

  // R13: an outstanding access keeps its address and direction
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: no burst starts without pending work on an enabled channel
  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !(pend && chan_en)) |=> (st_q == ST_IDLE));

  // R11: a failed write returns straight to idle
  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WRITE) && mem_ack && mem_err) |=> (st_q == ST_IDLE));

  // R3: each read is followed by a write of the same beat
  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_READ) && mem_ack) |=> (mem_req && mem_we));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dreq,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              chan_en,
  output logic              done_o,
  output logic              irq_o,
  output logic              err_o
);

  logic [1:0]        rs_q;
  logic              rst_s;
  logic              pend, take, src_adv, dst_adv, loop_end, xfer_abort;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [1:0]        src_sz, dst_sz;
  logic [CNT_W-1:0]  chunk;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  dma_desc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_desc (
    .clk        (clk),
    .rst_n      (rst_s),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .src_adv    (src_adv),
    .dst_adv    (dst_adv),
    .loop_end   (loop_end),
    .xfer_abort (xfer_abort),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .src_sz     (src_sz),
    .dst_sz     (dst_sz),
    .chunk      (chunk),
    .chan_en    (chan_en),
    .flag_done  (done_o),
    .flag_irq   (irq_o),
    .flag_err   (err_o)
  );

  dma_req_track u_req (
    .clk     (clk),
    .rst_n   (rst_s),
    .dreq    (dreq),
    .chan_en (chan_en),
    .take    (take),
    .pend    (pend)
  );

  dma_xfer_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .pend       (pend),
    .chan_en    (chan_en),
    .chunk      (chunk),
    .src_sz     (src_sz),
    .dst_sz     (dst_sz),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_rdata  (mem_rdata),
    .take       (take),
    .src_adv    (src_adv),
    .dst_adv    (dst_adv),
    .loop_end   (loop_end),
    .xfer_abort (xfer_abort),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata)
  );

  // R12: nothing is requested from memory while held in reset
  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |-> (!mem_req && !done_o && !err_o));

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        dreq;
  logic        mem_ack, mem_err;
  logic [31:0] mem_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        chan_en, done_o, irq_o, err_o;

  always #4 clk = ~clk;  // 125 MHz

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .chan_en(chan_en), .done_o(done_o), .irq_o(irq_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit test_over = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  s;
  } wr_t;
  wr_t exp_q[$];
  wr_t e;

  // reference model state
  logic [31:0] m_src, m_dst, m_sadj, m_dadj;
  int          m_sstep, m_dstep, m_ssz, m_dsz, m_chunk, m_iter, m_load;
  bit          m_irqen, m_stop, m_en, m_done, m_irq, m_err;

  bit          inj_err = 0;
  int          bus_cnt = 0;
  bit          wait_st = 0;
  logic [31:0] first_addr;

  function automatic logic [31:0] srcval(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: two-cycle latency, samples and drives on the falling edge
  always @(negedge clk) begin
    if (mem_req) bus_cnt++;
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_req) begin
      if (!wait_st) begin
        wait_st    <= 1'b1;
        first_addr <= mem_addr;
      end else begin
        wait_st <= 1'b0;
        chk("R13 address held while waiting", mem_addr, first_addr);
        mem_ack   <= 1'b1;
        mem_rdata <= srcval(mem_addr);
        if (mem_we) begin
          if (inj_err) mem_err <= 1'b1;
          else if (exp_q.size() == 0) chk("R3 unexpected write", 32'd1, 32'd0);
          else begin
            e = exp_q.pop_front();
            chk("R4 write address", mem_addr, e.a);
            chk("R3 write data", mem_wdata, e.d);
            chk("R3 write size", {30'd0, mem_size}, {30'd0, e.s});
          end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [4:0] b);
    wr(4'd10, {27'd0, b});
    if (b[0]) m_en   = 1;
    if (b[1]) m_en   = 0;
    if (b[2]) m_done = 0;
    if (b[3]) m_irq  = 0;
    if (b[4]) m_err  = 0;
  endtask

  task automatic set_desc(input logic [31:0] s, d, input int ss, ds, sz_s, sz_d,
                          chunk, iter, load, input logic [31:0] sa, da,
                          input bit irqen, stop);
    wr(4'd0, s);  wr(4'd1, d);
    wr(4'd2, {ds[15:0], ss[15:0]});
    wr(4'd3, {22'd0, sz_d[1:0], 6'd0, sz_s[1:0]});
    wr(4'd4, chunk); wr(4'd5, iter); wr(4'd6, load);
    wr(4'd7, sa); wr(4'd8, da);
    wr(4'd9, {30'd0, stop, irqen});
    m_src = s; m_dst = d; m_sstep = ss; m_dstep = ds;
    m_ssz = (sz_s == 3) ? 2 : sz_s; m_dsz = (sz_d == 3) ? 2 : sz_d;
    m_chunk = chunk; m_iter = iter; m_load = load;
    m_sadj = sa; m_dadj = da; m_irqen = irqen; m_stop = stop;
  endtask

  task automatic model_loop();
    int beats;
    wr_t w;
    if (!m_en) return;
    beats = m_chunk >> m_ssz;
    if (beats == 0) beats = 1;
    for (int i = 0; i < beats; i++) begin
      w.a = m_dst; w.d = srcval(m_src); w.s = m_dsz[1:0];
      exp_q.push_back(w);
      m_src = m_src + 32'(m_sstep);
      m_dst = m_dst + 32'(m_dstep);
    end
    if (m_iter <= 1) begin
      m_iter = m_load;
      m_src = m_src + m_sadj;
      m_dst = m_dst + m_dadj;
      m_done = 1;
      if (m_irqen) m_irq = 1;
      if (m_stop)  m_en  = 0;
    end else m_iter--;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic wait_quiet();
    repeat (3) @(negedge clk);
    while (mem_req || mem_ack) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic req_and_wait();
    model_loop();
    pulse();
    wait_quiet();
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " done"}, {31'd0, done_o},  {31'd0, m_done});
    chk({tag, " irq"},  {31'd0, irq_o},   {31'd0, m_irq});
    chk({tag, " err"},  {31'd0, err_o},   {31'd0, m_err});
    chk({tag, " en"},   {31'd0, chan_en}, {31'd0, m_en});
    chk({tag, " queue empty"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!test_over) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int bc;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; dreq = 1'b0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    m_en = 0; m_done = 0; m_irq = 0; m_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk_flags("R12 reset");
    chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);

    // word copy into fixed register, 8 requests per block, disable at end
    set_desc(32'h100, 32'h4000_0010, 4, 0, 2, 2, 4, 8, 8, -32'sd32, 0, 1, 1);
    // R2 request before enabling does nothing
    bc = bus_cnt; pulse(); wait_quiet();
    chk("R2 no access while disabled", bus_cnt, bc);
    cmd(5'b00001);
    for (int i = 0; i < 8; i++) begin
      req_and_wait();
      if (i < 7) chk("R5 done not yet", {31'd0, done_o}, 32'd0);
    end
    chk_flags("R7 R8 R9 block end");
    bc = bus_cnt; pulse(); wait_quiet();
    chk("R9 request after auto-disable ignored", bus_cnt, bc);
    cmd(5'b00100);
    chk_flags("R7 done cleared, R8 irq kept");
    cmd(5'b01000);
    chk_flags("R8 irq cleared");

    // second block: source corrected back to start, count reloaded
    cmd(5'b00001);
    for (int i = 0; i < 8; i++) req_and_wait();
    chk_flags("R6 reload and correction");
    cmd(5'b01100);

    // halfword bursts, both addresses stepping, no interrupt, no stop
    set_desc(32'h1000, 32'h2000, 2, 2, 1, 1, 8, 3, 3, 32'h10, -32'sd8, 0, 0);
    cmd(5'b00001);
    model_loop(); model_loop();
    pulse();
    repeat (3) @(negedge clk);
    pulse(); pulse();  // R10 arrive mid-burst, merge into one
    wait_quiet();
    chk_flags("R10 held request serviced once");
    req_and_wait();
    chk_flags("R8 R9 end without irq or stop");
    req_and_wait();
    chk_flags("R6 R4 after correction");

    // R2 explicit disable
    cmd(5'b00010);
    bc = bus_cnt; pulse(); wait_quiet();
    chk("R2 disabled channel idle", bus_cnt, bc);
    chk_flags("R2 disabled flags");

    // byte bursts, one iteration per block
    set_desc(32'h3001, 32'h3100, 1, 0, 0, 0, 3, 1, 1, 0, 0, 1, 0);
    cmd(5'b01101);  // R1 combined command bits
    chk_flags("R1 combined command");
    req_and_wait();
    chk_flags("R5 single iteration block");
    req_and_wait();
    chk_flags("R5 R6 reload of one");
    cmd(5'b01100);

    // failed destination write
    set_desc(32'h200, 32'h300, 4, 4, 2, 2, 8, 2, 2, 0, 0, 0, 0);
    cmd(5'b00001);
    inj_err = 1;
    m_src = m_src + 32'd4; m_err = 1; m_en = 0;  // R11 one read done, write fails
    pulse(); wait_quiet();
    inj_err = 0;
    chk_flags("R11 abort");
    cmd(5'b10001);
    chk_flags("R11 error cleared");
    req_and_wait();
    chk_flags("R11 count unchanged by abort");
    req_and_wait();
    chk_flags("R11 block ends one request later");

    test_over = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule